// File: doc/BRIEF.md
# OLED Controller Command Byte Decoder

This block sits behind a serial slave front end that delivers whole bytes, one per cycle, together with a level that says whether the byte is a command or pixel data. In command mode it reads the first byte as an opcode, looks up how many argument bytes that opcode needs, and collects them. Only when the last argument arrives does it apply the command and pulse a strobe. Opcodes that set the column window, set the row window or set the remap mode change registers that the block drives out. All other known opcodes are parsed and then dropped, and their arguments are still shown to downstream logic with the strobe.

In data mode each byte is sent to a frame-memory write port. The address comes from a column and row cursor that steps through the current window, either along columns or along rows depending on the remap mode. The cursor wraps inside the window. A command can be interrupted by data bytes and finished later.

Top module: `oled_cmd_decoder`

## Requirements
- R1: Opcode 0x15 takes two arguments. On the edge that accepts the second one, `col_lo` becomes the first argument modulo 64, `col_hi` becomes the second modulo 64, and the cursor column is loaded with the new `col_lo`.
- R2: Opcode 0x75 takes two arguments. `row_lo` and `row_hi` become the first and second argument modulo 80, and the cursor row is loaded with the new `row_lo`.
- R3: Opcode 0xA0 takes one argument and stores it in `remap_q`. Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF also take one argument but change neither the windows nor `remap_q`.
- R4: Opcodes 0x84 to 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3 complete on the opcode byte. A completing command raises `cmd_strobe` for exactly one cycle, after the edge that takes its last byte, with `cmd_code` set to the opcode. The next command byte is read as a new opcode.
- R5: Opcode 0xB8 takes eight arguments. With its strobe, argument k (k counted from 0) appears on `cmd_args[8k+7:8k]`.
- R6: Opcode 0xFF completes on its own byte with a strobe and no other effect.
- R7: An opcode that is not listed in R1 to R6 raises `bad_opcode` for one cycle and no strobe. The next command byte is read as a new opcode.
- R8: After reset the column window is 0..63, the row window is 0..79, the cursor is at column 0 and row 0, `remap_q` is 0, and no strobe, error or write is active.
- R9: A data byte produces one cycle of `wr_en` after its edge, with `wr_data` equal to the byte and `wr_addr` equal to row*64+column of the cursor before that byte.
- R10: When `remap_q` bit 2 is 0, each write advances the column. Past `col_hi` the column returns to `col_lo` and the row advances. A row past `row_hi` returns to `row_lo`.
- R11: When `remap_q` bit 2 is 1, each write advances the row. Past `row_hi` the row returns to `row_lo` and the column advances. A column past `col_hi` returns to `col_lo`.
- R12: Data bytes that arrive between the bytes of a command are written normally and leave the partial command pending. The next command byte continues that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_byte | input | 8 | Byte from the serial front end |
| in_is_data | input | 1 | 1 = pixel data, 0 = command stream |
| col_lo | output | 6 | Column window start |
| col_hi | output | 6 | Column window end |
| row_lo | output | 7 | Row window start |
| row_hi | output | 7 | Row window end |
| remap_q | output | 8 | Remap mode byte; bit 2 selects row-first stepping |
| cmd_strobe | output | 1 | One-cycle pulse per completed known command |
| cmd_code | output | 8 | Opcode of the completed command |
| cmd_args | output | 64 | Arguments of the completed command, byte k at bits 8k+7:8k |
| bad_opcode | output | 1 | One-cycle pulse for an unknown opcode |
| wr_en | output | 1 | Frame-memory write enable |
| wr_addr | output | 13 | Frame-memory address, row*64+column |
| wr_data | output | 8 | Frame-memory write data |

## Verification
Directed sequences cover each class of argument count: none, one, two and eight. They also cover arguments at 0xFF, where reduction modulo 64 and modulo 80 give different results. Bursts of data bytes run in a narrow window under both stepping modes, so column-first and row-first wrapping give different addresses. A two-argument command is split by data bytes to show that the partial command is kept. A seeded random mix of opcodes, unknown bytes, arguments, data bursts and idle cycles then checks each output against a bench model on every cycle. This catches mistakes in argument counting and counter reset that only show up in long interleavings.

// File: rtl/oled_dec_pkg.sv
package oled_dec_pkg;
  localparam logic [7:0] OP_COL_WIN = 8'h15;
  localparam logic [7:0] OP_ROW_WIN = 8'h75;
  localparam logic [7:0] OP_REMAP   = 8'hA0;
  localparam logic [7:0] OP_GREY    = 8'hB8;
  localparam logic [7:0] OP_IDLE    = 8'hFF;
  localparam int         GREY_ARGS  = 8;
endpackage

// File: rtl/oled_opcode_table.sv
module oled_opcode_table
  import oled_dec_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [7:0]       opcode,
  output logic [CNT_W-1:0] nargs,
  output logic             known
);
  always_comb begin
    known = 1'b1;
    nargs = '0;
    case (opcode)
      OP_COL_WIN, OP_ROW_WIN: nargs = CNT_W'(2);
      OP_REMAP, 8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
      8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: nargs = CNT_W'(1);
      OP_GREY: nargs = CNT_W'(GREY_ARGS);
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
      8'hAE, 8'hAF, 8'hE3, OP_IDLE: nargs = '0;
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/oled_cmd_collect.sv
module oled_cmd_collect
  import oled_dec_pkg::*;
#(
  parameter int MAX_ARGS = 8,
  localparam int CNT_W = $clog2(MAX_ARGS + 1),
  localparam int IDX_W = $clog2(MAX_ARGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [7:0]            in_byte,
  input  logic                  in_is_data,
  input  logic [CNT_W-1:0]      tbl_nargs,
  input  logic                  tbl_known,
  output logic                  apply_col,
  output logic                  apply_row,
  output logic                  apply_remap,
  output logic [7:0]            arg0,
  output logic [7:0]            arg1,
  output logic                  cmd_strobe,
  output logic [7:0]            cmd_code,
  output logic [MAX_ARGS*8-1:0] cmd_args,
  output logic                  bad_opcode
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need_q;
  logic [7:0]       op_q;
  logic [7:0]       args_q [MAX_ARGS];

  logic             is_cmd, first, done, bad;
  logic [7:0]       op_now;
  logic [IDX_W-1:0] slot;

  always_comb begin
    is_cmd = in_valid && !in_is_data;
    first  = (cnt_q == '0);
    slot   = IDX_W'(cnt_q - 1'b1);
    op_now = first ? in_byte : op_q;
    done   = is_cmd && (first ? (tbl_known && tbl_nargs == '0) : (cnt_q == need_q));
    bad    = is_cmd && first && !tbl_known;
    arg0   = (cnt_q == CNT_W'(1)) ? in_byte : args_q[0];
    arg1   = (cnt_q == CNT_W'(2)) ? in_byte : args_q[1];
    apply_col   = done && op_now == OP_COL_WIN;
    apply_row   = done && op_now == OP_ROW_WIN;
    apply_remap = done && op_now == OP_REMAP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      need_q     <= '0;
      op_q       <= '0;
      cmd_strobe <= 1'b0;
      bad_opcode <= 1'b0;
      cmd_code   <= '0;
      cmd_args   <= '0;
      for (int k = 0; k < MAX_ARGS; k++) args_q[k] <= '0;
    end else begin
      cmd_strobe <= done;
      bad_opcode <= bad;
      if (done) cmd_code <= op_now;
      if (is_cmd) begin
        if (first) begin
          op_q   <= in_byte;
          need_q <= tbl_nargs;
          if (tbl_known && tbl_nargs != '0) cnt_q <= CNT_W'(1);
        end else begin
          args_q[slot] <= in_byte;
          cnt_q        <= done ? '0 : CNT_W'(cnt_q + 1'b1);
        end
      end
      if (done) begin
        for (int k = 0; k < MAX_ARGS; k++)
          cmd_args[k*8 +: 8] <= (!first && slot == IDX_W'(k)) ? in_byte : args_q[k];
      end
    end
  end
endmodule

// File: rtl/oled_window_cursor.sv
module oled_window_cursor #(
  parameter int NUM_COLS = 64,
  parameter int NUM_ROWS = 80,
  localparam int COL_W  = $clog2(NUM_COLS),
  localparam int ROW_W  = $clog2(NUM_ROWS),
  localparam int ADDR_W = $clog2(NUM_COLS * NUM_ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              apply_col,
  input  logic              apply_row,
  input  logic              apply_remap,
  input  logic [7:0]        arg0,
  input  logic [7:0]        arg1,
  input  logic              wr_req,
  input  logic [7:0]        wr_byte,
  output logic [COL_W-1:0]  col_lo,
  output logic [COL_W-1:0]  col_hi,
  output logic [ROW_W-1:0]  row_lo,
  output logic [ROW_W-1:0]  row_hi,
  output logic [7:0]        remap_q,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int VERT_BIT = 2;

  logic [COL_W-1:0] cur_c;
  logic [ROW_W-1:0] cur_r;
  logic [COL_W:0]   nc;
  logic [ROW_W:0]   nr;
  logic [COL_W-1:0] arg0_c, arg1_c;
  logic [ROW_W-1:0] arg0_r, arg1_r;

  always_comb begin
    arg0_c = COL_W'(arg0 % NUM_COLS);
    arg1_c = COL_W'(arg1 % NUM_COLS);
    arg0_r = ROW_W'(arg0 % NUM_ROWS);
    arg1_r = ROW_W'(arg1 % NUM_ROWS);
  end

  // Next cursor position after one write, column-first or row-first
  always_comb begin
    if (!remap_q[VERT_BIT]) begin
      nc = {1'b0, cur_c} + 1'b1;
      nr = {1'b0, cur_r};
      if (nc > {1'b0, col_hi}) begin
        nc = {1'b0, col_lo};
        nr = {1'b0, cur_r} + 1'b1;
      end
      if (nr > {1'b0, row_hi}) nr = {1'b0, row_lo};
    end else begin
      nr = {1'b0, cur_r} + 1'b1;
      nc = {1'b0, cur_c};
      if (nr > {1'b0, row_hi}) begin
        nr = {1'b0, row_lo};
        nc = {1'b0, cur_c} + 1'b1;
      end
      if (nc > {1'b0, col_hi}) nc = {1'b0, col_lo};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_lo  <= '0;
      col_hi  <= COL_W'(NUM_COLS - 1);
      row_lo  <= '0;
      row_hi  <= ROW_W'(NUM_ROWS - 1);
      cur_c   <= '0;
      cur_r   <= '0;
      remap_q <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= wr_req;
      if (wr_req) begin
        wr_addr <= ADDR_W'(cur_r) * ADDR_W'(NUM_COLS) + ADDR_W'(cur_c);
        wr_data <= wr_byte;
        cur_c   <= COL_W'(nc);
        cur_r   <= ROW_W'(nr);
      end
      if (apply_col) begin
        col_lo <= arg0_c;
        col_hi <= arg1_c;
        cur_c  <= arg0_c;
      end
      if (apply_row) begin
        row_lo <= arg0_r;
        row_hi <= arg1_r;
        cur_r  <= arg0_r;
      end
      if (apply_remap) remap_q <= arg0;
    end
  end
endmodule

// File: rtl/oled_cmd_decoder.sv
module oled_cmd_decoder #(
  parameter int NUM_COLS = 64,
  parameter int NUM_ROWS = 80,
  parameter int MAX_ARGS = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  in_valid,
  input  logic [7:0]                            in_byte,
  input  logic                                  in_is_data,
  output logic [$clog2(NUM_COLS)-1:0]           col_lo,
  output logic [$clog2(NUM_COLS)-1:0]           col_hi,
  output logic [$clog2(NUM_ROWS)-1:0]           row_lo,
  output logic [$clog2(NUM_ROWS)-1:0]           row_hi,
  output logic [7:0]                            remap_q,
  output logic                                  cmd_strobe,
  output logic [7:0]                            cmd_code,
  output logic [MAX_ARGS*8-1:0]                 cmd_args,
  output logic                                  bad_opcode,
  output logic                                  wr_en,
  output logic [$clog2(NUM_COLS*NUM_ROWS)-1:0]  wr_addr,
  output logic [7:0]                            wr_data
);
  localparam int CNT_W = $clog2(MAX_ARGS + 1);

  logic [CNT_W-1:0] tbl_nargs;
  logic             tbl_known;
  logic             apply_col, apply_row, apply_remap;
  logic [7:0]       arg0, arg1;

  oled_opcode_table #(.CNT_W(CNT_W)) u_table (
    .opcode (in_byte),
    .nargs  (tbl_nargs),
    .known  (tbl_known)
  );

  oled_cmd_collect #(.MAX_ARGS(MAX_ARGS)) u_collect (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_byte     (in_byte),
    .in_is_data  (in_is_data),
    .tbl_nargs   (tbl_nargs),
    .tbl_known   (tbl_known),
    .apply_col   (apply_col),
    .apply_row   (apply_row),
    .apply_remap (apply_remap),
    .arg0        (arg0),
    .arg1        (arg1),
    .cmd_strobe  (cmd_strobe),
    .cmd_code    (cmd_code),
    .cmd_args    (cmd_args),
    .bad_opcode  (bad_opcode)
  );

  oled_window_cursor #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_cursor (
    .clk         (clk),
    .rst         (rst),
    .apply_col   (apply_col),
    .apply_row   (apply_row),
    .apply_remap (apply_remap),
    .arg0        (arg0),
    .arg1        (arg1),
    .wr_req      (in_valid && in_is_data),
    .wr_byte     (in_byte),
    .col_lo      (col_lo),
    .col_hi      (col_hi),
    .row_lo      (row_lo),
    .row_hi      (row_hi),
    .remap_q     (remap_q),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
  );
endmodule

// File: rtl/oled_dec_checker.sv
module oled_dec_checker #(
  parameter int NUM_COLS = 64,
  parameter int NUM_ROWS = 80
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 in_valid,
  input logic [7:0]                           in_byte,
  input logic                                 in_is_data,
  input logic [$clog2(NUM_COLS)-1:0]          col_lo,
  input logic [$clog2(NUM_COLS)-1:0]          col_hi,
  input logic [$clog2(NUM_ROWS)-1:0]          row_lo,
  input logic [$clog2(NUM_ROWS)-1:0]          row_hi,
  input logic                                 cmd_strobe,
  input logic [7:0]                           cmd_code,
  input logic [15:0]                          args_lo,
  input logic                                 bad_opcode,
  input logic                                 wr_en,
  input logic [$clog2(NUM_COLS*NUM_ROWS)-1:0] wr_addr,
  input logic [7:0]                           wr_data
);
  localparam int COL_W = $clog2(NUM_COLS);
  localparam int ROW_W = $clog2(NUM_ROWS);

  // R1
  col_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && cmd_code == 8'h15) |->
      (col_lo == COL_W'(args_lo[7:0] % NUM_COLS) && col_hi == COL_W'(args_lo[15:8] % NUM_COLS)));
  // R2
  row_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && cmd_code == 8'h75) |->
      (row_lo == ROW_W'(args_lo[7:0] % NUM_ROWS) && row_hi == ROW_W'(args_lo[15:8] % NUM_ROWS)));
  // R2
  row_range_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(row_lo) < NUM_ROWS) && (32'(row_hi) < NUM_ROWS));
  // R4
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |-> $past(in_valid && !in_is_data));
  // R7
  bad_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(bad_opcode && cmd_strobe));
  // R7
  bad_src_chk: assert property (@(posedge clk) disable iff (rst)
    bad_opcode |-> $past(in_valid && !in_is_data));
  // R9
  wr_src_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(in_valid && in_is_data) && wr_data == $past(in_byte)));
  // R9
  wr_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (32'(wr_addr) < NUM_ROWS * NUM_COLS));
endmodule

bind oled_cmd_decoder oled_dec_checker #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_byte    (in_byte),
  .in_is_data (in_is_data),
  .col_lo     (col_lo),
  .col_hi     (col_hi),
  .row_lo     (row_lo),
  .row_hi     (row_hi),
  .cmd_strobe (cmd_strobe),
  .cmd_code   (cmd_code),
  .args_lo    (cmd_args[15:0]),
  .bad_opcode (bad_opcode),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data)
);

// File: tb/test_oled_cmd_decoder.sv
`timescale 1ns/1ps
module test_oled_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_is_data;
  logic [5:0]  col_lo, col_hi;
  logic [6:0]  row_lo, row_hi;
  logic [7:0]  remap_q, cmd_code, wr_data;
  logic        cmd_strobe, bad_opcode, wr_en;
  logic [63:0] cmd_args;
  logic [12:0] wr_addr;

  oled_cmd_decoder i_oled_cmd_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_is_data(in_is_data),
    .col_lo(col_lo), .col_hi(col_hi), .row_lo(row_lo), .row_hi(row_hi), .remap_q(remap_q),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .cmd_args(cmd_args), .bad_opcode(bad_opcode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench model
  int m_cnt, m_need, m_cl, m_ch, m_rl, m_rh, m_c, m_r;
  logic [7:0]  m_op, m_remap;
  logic [7:0]  m_args [8];
  logic        e_strobe, e_bad, e_wr;
  logic [7:0]  e_code, e_data;
  int          e_addr;
  logic [63:0] e_args;

  function automatic int nargs(input logic [7:0] op);
    case (op)
      8'h15, 8'h75: return 2;
      8'hB8: return 8;
      8'h81, 8'hA0, 8'hA1, 8'hA2, 8'hA8, 8'hAD, 8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: return 1;
      8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hAE, 8'hAF, 8'hE3, 8'hFF: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] pick_op(input int k);
    case (k)
      0: return 8'h15;  1: return 8'h75;  2: return 8'hA0;  3: return 8'hA0;
      4: return 8'h81;  5: return 8'hA4;  6: return 8'hFF;  7: return 8'hB8;
      8: return 8'hAE;  9: return 8'hE3;  10: return 8'hA8; 11: return 8'h84;
      12: return 8'h75; 13: return 8'h15; 14: return 8'hBF;
      default: return 8'($urandom);
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_need = 0; m_cl = 0; m_ch = 63; m_rl = 0; m_rh = 79; m_c = 0; m_r = 0;
    m_remap = 0; m_op = 0;
    e_strobe = 0; e_bad = 0; e_wr = 0; e_code = 0; e_data = 0; e_addr = 0; e_args = 0;
  endtask

  task automatic complete();
    e_strobe = 1; e_code = m_op;
    case (m_op)
      8'h15: begin m_cl = m_args[0] % 64; m_ch = m_args[1] % 64; m_c = m_cl; end
      8'h75: begin m_rl = m_args[0] % 80; m_rh = m_args[1] % 80; m_r = m_rl; end
      8'hA0: m_remap = m_args[0];
      8'hB8: for (int k = 0; k < 8; k++) e_args[k*8 +: 8] = m_args[k];
      default: ;
    endcase
    m_cnt = 0;
  endtask

  task automatic model_step(input logic [7:0] b, input logic d);
    e_strobe = 0; e_bad = 0; e_wr = 0;
    if (d) begin
      e_wr = 1; e_addr = m_r * 64 + m_c; e_data = b;
      if (!m_remap[2]) begin
        m_c++;
        if (m_c > m_ch) begin m_c = m_cl; m_r++; end
        if (m_r > m_rh) m_r = m_rl;
      end else begin
        m_r++;
        if (m_r > m_rh) begin m_r = m_rl; m_c++; end
        if (m_c > m_ch) m_c = m_cl;
      end
    end else if (m_cnt == 0) begin
      m_op = b;
      if (nargs(b) < 0) e_bad = 1;
      else if (nargs(b) == 0) complete();
      else begin m_need = nargs(b); m_cnt = 1; end
    end else begin
      m_args[m_cnt-1] = b;
      if (m_cnt == m_need) complete();
      else m_cnt++;
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " strobe"}, 64'(cmd_strobe), 64'(e_strobe));
    if (e_strobe) chk({tag, " code"}, 64'(cmd_code), 64'(e_code));
    chk({tag, " R7 bad_opcode"}, 64'(bad_opcode), 64'(e_bad));
    chk("R9 wr_en", 64'(wr_en), 64'(e_wr));
    if (e_wr) begin
      chk(m_remap[2] ? "R11 wr_addr" : "R10 wr_addr", 64'(wr_addr), 64'(e_addr));
      chk("R9 wr_data", 64'(wr_data), 64'(e_data));
    end
    chk("R1 col_lo", 64'(col_lo), 64'(m_cl));
    chk("R1 col_hi", 64'(col_hi), 64'(m_ch));
    chk("R2 row_lo", 64'(row_lo), 64'(m_rl));
    chk("R2 row_hi", 64'(row_hi), 64'(m_rh));
    chk("R3 remap_q", 64'(remap_q), 64'(m_remap));
    if (e_strobe && e_code == 8'hB8) chk("R5 cmd_args", cmd_args, e_args);
  endtask

  task automatic push(input logic [7:0] b, input logic d, input string tag);
    in_valid = 1; in_byte = b; in_is_data = d;
    model_step(b, d);
    @(negedge clk);
    in_valid = 0;
    compare(tag);
  endtask

  task automatic idle();
    in_valid = 0; e_strobe = 0; e_bad = 0; e_wr = 0;
    @(negedge clk);
    compare("R4 idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; in_valid = 0; in_byte = 0; in_is_data = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare("R8 reset");
    // R8: cursor starts at 0,0
    push(8'h11, 1, "R8"); push(8'h22, 1, "R9");
    // R1: modulo 64 on end argument (0x46 -> 6)
    push(8'h15, 0, "R1"); push(8'h04, 0, "R1"); push(8'h46, 0, "R1");
    // R2: modulo 80 on start argument (0xA3 -> 3)
    push(8'h75, 0, "R2"); push(8'hA3, 0, "R2"); push(8'h05, 0, "R2");
    // R10: column-first stepping through a 3x3 window
    for (int i = 0; i < 11; i++) push(8'(i + 8'h30), 1, "R10");
    // R3: remap with vertical stepping
    push(8'hA0, 0, "R3"); push(8'h04, 0, "R3");
    // R11: row-first stepping
    for (int i = 0; i < 11; i++) push(8'(i + 8'h50), 1, "R11");
    // R3: one-argument opcodes without effect
    push(8'h81, 0, "R3"); push(8'hFF, 0, "R3");
    push(8'hBE, 0, "R3"); push(8'hA0, 0, "R3");
    // R4: zero-argument opcodes
    push(8'hA4, 0, "R4"); push(8'hAF, 0, "R4"); push(8'hE3, 0, "R4");
    // R6: idle opcode
    push(8'hFF, 0, "R6");
    // R7: unknown opcodes followed by a new opcode
    push(8'h00, 0, "R7"); push(8'h16, 0, "R7"); push(8'hE3, 0, "R7");
    // R5: eight-argument opcode
    push(8'hB8, 0, "R5");
    for (int i = 0; i < 8; i++) push(8'(8'h90 + i * 8'h11), 0, "R5");
    // R12: command split by data bytes
    push(8'hA0, 0, "R12"); push(8'h00, 0, "R12");
    push(8'h15, 0, "R12"); push(8'h02, 0, "R12");
    push(8'hC1, 1, "R12"); idle(); push(8'hC2, 1, "R12");
    push(8'h03, 0, "R12");
    push(8'hC3, 1, "R12");
    // R1 and R2: arguments at 0xFF
    push(8'h15, 0, "R1"); push(8'hFF, 0, "R1"); push(8'hFF, 0, "R1");
    push(8'h75, 0, "R2"); push(8'hFF, 0, "R2"); push(8'hFF, 0, "R2");
    push(8'h77, 1, "R9");
    // Random mix
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 4) push(8'($urandom), 1, "R9 random");
      else if (r == 9) idle();
      else if (m_cnt == 0) push(pick_op(int'($urandom % 16)), 0, "R4 random");
      else push(8'($urandom), 0, "R4 random");
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule